// File: doc/BRIEF.md
# CCD Sampling Timing Sequencer

This block turns a master clock and an active-high per-pixel sync pulse into the internal strobes that drive a three-channel CCD front end. It produces a video-sample strobe, a reset-sample strobe, a reset-level clamp pulse and a channel index with a slot-valid flag. The index steers a shared converter through red, green and blue in colour operation, or holds it on one chosen channel in monochrome operation. Six operating modes are reached by combining a monochrome bit, a CDS bit, a maximum-speed bit and a two-bit rate field. These modes differ in how many master clocks make up one pixel (2, 3, 6 or 8) and in which converter slots carry real data.

A pixel step counter restarts whenever the sync pulse is sampled high. Every strobe is decoded from that counter. A strobe that is high in the cycle after the counter reaches step n marks the n-th master-clock rising edge after the sync edge. The reset sample and the clamp can be moved earlier or later by a two-bit adjust field. The clamp always moves together with the programmed reset-sample position.

Top module: `ccd_sample_seq`

## Requirements
- R1: While reset is held and after it is released with no sync, vs_o, rs_o, cl_o and slot_valid_o are low.
- R2: When sync_i is sampled high on a rising edge, vs_o is high for exactly the following clock cycle, marking the first rising edge after the sync edge. vs_o is never high at any other time.
- R3: With CDS active (cfg_cds_i=1, cfg_maxspd_i=0), rs_o is high for one cycle, marking rising edge 3+A after the sync edge, where A is cfg_rs_adj_i (00 gives edge 3, 01 edge 4, 10 edge 5, 11 edge 6). It fires only if that edge lies within the pixel.
- R4: In single-ended operation (cfg_cds_i=0) and in maximum-speed mode (cfg_maxspd_i=1), rs_o is high exactly when vs_o is high.
- R5: clamp_req_i is sampled on the first rising edge after the sync edge. If it was high, cl_o is high in the cycle that marks edge 3+A (three edges after the request edge when A=01), whether or not CDS is active. It does not fire if that edge lies beyond the pixel.
- R6: Pixel length in clocks is 2 when cfg_maxspd_i=1. Otherwise it is set by cfg_rate_i: 01 gives 3, 10 gives 8, and 00 or 11 gives 6. After that many cycles with no new sync, the block is idle: every strobe is low and slot_valid_o is low.
- R7: In colour operation, a pixel of 6 or 8 clocks is split into two-clock slots that carry chan_o = 00 (red), 01 (green) and 10 (blue), each with slot_valid_o high. The fourth slot of an 8-clock pixel carries chan_o = 11 with slot_valid_o low. When idle in colour operation, chan_o is 00.
- R8: Monochrome operation applies when cfg_mono_i=1, cfg_maxspd_i=1 or cfg_rate_i=01. In it, chan_o always equals cfg_chan_i. In 6- and 8-clock pixels, slot_valid_o is high only in the first two-clock slot. In 2- and 3-clock pixels, it is high for the whole pixel.
- R9: A sync pulse that arrives before the pixel length has elapsed restarts the sequence at its first step. It also discards any clamp request armed for the interrupted pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Active-high per-pixel sync pulse |
| clamp_req_i | input | 1 | Clamp request for the current pixel |
| cfg_mono_i | input | 1 | 1 = monochrome operation |
| cfg_cds_i | input | 1 | 1 = correlated double sampling, 0 = single-ended |
| cfg_maxspd_i | input | 1 | 1 = maximum-speed monochrome (2-clock pixel, no CDS) |
| cfg_rate_i | input | 2 | Pixel length select: 00 normal, 01 fast, 10 slow, 11 normal |
| cfg_chan_i | input | 2 | Monochrome channel: 00 red, 01 green, 10 blue |
| cfg_rs_adj_i | input | 2 | Reset-sample and clamp position adjust |
| vs_o | output | 1 | Video-sample strobe |
| rs_o | output | 1 | Reset-sample strobe |
| cl_o | output | 1 | Reset-level clamp pulse |
| chan_o | output | 2 | Converter channel index |
| slot_valid_o | output | 1 | Current converter slot carries valid data |

## Verification
The properties assume that the configuration inputs are quasi-static: they change only while no pixel is in flight. The strobe relations are judged against the configuration present in the same cycle. They also assume that sync_i is a synchronous level sampled on each rising edge. The stimulus meets both assumptions. It writes each configuration on a falling edge while the block is idle, and it raises sync_i for one cycle per pixel. The only exception is the deliberate early restart, which also leaves the configuration untouched.

// File: rtl/sts_pkg.sv
package sts_pkg;
   // pixel-length selector carried on cfg_rate_i
   typedef enum logic [1:0] {
      RATE_NORMAL = 2'b00,
      RATE_FAST   = 2'b01,
      RATE_SLOW   = 2'b10,
      RATE_SPARE  = 2'b11
   } rate_e;

   localparam logic [1:0] CH_RED   = 2'b00;
   localparam logic [1:0] CH_GREEN = 2'b01;
   localparam logic [1:0] CH_BLUE  = 2'b10;
   localparam logic [1:0] CH_NONE  = 2'b11;
endpackage

// File: rtl/sts_phase_ctr.sv
module sts_phase_ctr #(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sync_i,
   input  logic [PH_W-1:0] ratio_i,
   output logic [PH_W-1:0] ph_o
);
   // 0 = idle, 1..ratio = step within the pixel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_o <= '0;
      else if (sync_i)
         ph_o <= PH_W'(1);
      else if (ph_o != '0 && ph_o < ratio_i)
         ph_o <= ph_o + PH_W'(1);
      else
         ph_o <= '0;
   end
endmodule

// File: rtl/sts_strobe_gen.sv
module sts_strobe_gen #(
   parameter int PH_W    = 4,
   parameter int RS_BASE = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sync_i,
   input  logic [PH_W-1:0] ph_i,
   input  logic            clamp_req_i,
   input  logic            cds_active_i,
   input  logic [1:0]      rs_adj_i,
   output logic            vs_o,
   output logic            rs_o,
   output logic            cl_o
);
   localparam logic [PH_W-1:0] STEP_ONE = PH_W'(1);
   localparam logic [PH_W-1:0] POS_MIN  = PH_W'(RS_BASE - 1);

   logic [PH_W-1:0] rs_pos;
   logic            clamp_armed;

   assign rs_pos = POS_MIN + PH_W'(rs_adj_i);

   // request captured on the edge that takes the video sample;
   // a new sync discards whatever the interrupted pixel armed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         clamp_armed <= 1'b0;
      else if (sync_i)
         clamp_armed <= 1'b0;
      else if (ph_i == STEP_ONE)
         clamp_armed <= clamp_req_i;
   end

   always_comb begin
      vs_o = (ph_i == STEP_ONE);
      rs_o = cds_active_i ? (ph_i == rs_pos) : (ph_i == STEP_ONE);
      cl_o = clamp_armed && (ph_i == rs_pos);
   end
endmodule

// File: rtl/sts_chan_seq.sv
module sts_chan_seq
   import sts_pkg::*;
#(
   parameter int PH_W      = 4,
   parameter int SLOT_CLKS = 2
) (
   input  logic [PH_W-1:0] ph_i,
   input  logic [PH_W-1:0] ratio_i,
   input  logic            mono_i,
   input  logic [1:0]      chan_sel_i,
   output logic [1:0]      chan_o,
   output logic            valid_o
);
   localparam logic [PH_W-1:0] MULTI_MIN = PH_W'(3 * SLOT_CLKS);

   logic [PH_W-1:0] ph_m1;
   logic [PH_W-1:0] slot;
   logic            single_slot;

   assign ph_m1       = ph_i - PH_W'(1);
   assign single_slot = (ratio_i < MULTI_MIN);
   assign slot        = single_slot ? '0 : PH_W'(ph_m1 / PH_W'(SLOT_CLKS));

   always_comb begin
      if (ph_i == '0) begin
         chan_o  = mono_i ? chan_sel_i : CH_RED;
         valid_o = 1'b0;
      end else if (mono_i) begin
         chan_o  = chan_sel_i;
         valid_o = (slot == '0);
      end else if (slot < PH_W'(3)) begin
         chan_o  = slot[1:0];
         valid_o = 1'b1;
      end else begin
         chan_o  = CH_NONE;
         valid_o = 1'b0;
      end
   end
endmodule

// File: rtl/ccd_sample_seq.sv
module ccd_sample_seq
   import sts_pkg::*;
#(
   parameter int NORMAL_RATIO = 6,
   parameter int FAST_RATIO   = 3,
   parameter int MAX_RATIO    = 2,
   parameter int SLOW_RATIO   = 8,
   parameter int SLOT_CLKS    = 2,
   parameter int RS_BASE      = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_i,
   input  logic       clamp_req_i,
   input  logic       cfg_mono_i,
   input  logic       cfg_cds_i,
   input  logic       cfg_maxspd_i,
   input  logic [1:0] cfg_rate_i,
   input  logic [1:0] cfg_chan_i,
   input  logic [1:0] cfg_rs_adj_i,
   output logic       vs_o,
   output logic       rs_o,
   output logic       cl_o,
   output logic [1:0] chan_o,
   output logic       slot_valid_o
);
   localparam int PH_W = $clog2(SLOW_RATIO + 1);

   if (NORMAL_RATIO != 3 * SLOT_CLKS) begin : g_bad_normal
      $error("normal pixel must hold three converter slots");
   end
   if (SLOW_RATIO != 4 * SLOT_CLKS) begin : g_bad_slow
      $error("slow pixel must hold four converter slots");
   end
   if (FAST_RATIO >= 3 * SLOT_CLKS || MAX_RATIO >= 3 * SLOT_CLKS) begin : g_bad_short
      $error("short pixels must fit in a single slot");
   end
   if (RS_BASE < 3 || RS_BASE + 2 > SLOW_RATIO) begin : g_bad_rs
      $error("reset-sample base out of range");
   end

   logic [PH_W-1:0] ratio;
   logic [PH_W-1:0] ph;
   logic            mono_eff;
   logic            cds_active;

   always_comb begin
      if (cfg_maxspd_i)
         ratio = PH_W'(MAX_RATIO);
      else begin
         case (rate_e'(cfg_rate_i))
            RATE_FAST: ratio = PH_W'(FAST_RATIO);
            RATE_SLOW: ratio = PH_W'(SLOW_RATIO);
            default:   ratio = PH_W'(NORMAL_RATIO);
         endcase
      end
   end

   assign mono_eff   = cfg_mono_i | cfg_maxspd_i | (cfg_rate_i == RATE_FAST);
   assign cds_active = cfg_cds_i & ~cfg_maxspd_i;

   sts_phase_ctr #(.PH_W(PH_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_i),
      .ratio_i(ratio),
      .ph_o   (ph)
   );

   sts_strobe_gen #(.PH_W(PH_W), .RS_BASE(RS_BASE)) u_strb (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_i      (sync_i),
      .ph_i        (ph),
      .clamp_req_i (clamp_req_i),
      .cds_active_i(cds_active),
      .rs_adj_i    (cfg_rs_adj_i),
      .vs_o        (vs_o),
      .rs_o        (rs_o),
      .cl_o        (cl_o)
   );

   sts_chan_seq #(.PH_W(PH_W), .SLOT_CLKS(SLOT_CLKS)) u_chan (
      .ph_i      (ph),
      .ratio_i   (ratio),
      .mono_i    (mono_eff),
      .chan_sel_i(cfg_chan_i),
      .chan_o    (chan_o),
      .valid_o   (slot_valid_o)
   );
endmodule

// File: rtl/sts_checker.sv
module sts_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sync_i,
   input logic       cfg_mono_i,
   input logic       cfg_cds_i,
   input logic       cfg_maxspd_i,
   input logic [1:0] cfg_rate_i,
   input logic [1:0] cfg_chan_i,
   input logic       vs_o,
   input logic       rs_o,
   input logic       cl_o,
   input logic [1:0] chan_o,
   input logic       slot_valid_o
);
   logic mono_view;
   assign mono_view = cfg_mono_i | cfg_maxspd_i | (cfg_rate_i == 2'b01);

   assert_vs_follows_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> vs_o);

   assert_vs_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vs_o |-> $past(sync_i));

   assert_se_rs_with_vs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_cds_i || cfg_maxspd_i) |-> (rs_o == vs_o));

   assert_clamp_on_rs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_o && cfg_cds_i && !cfg_maxspd_i) |-> rs_o);

   assert_colour_chan_real_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid_o && !mono_view) |-> (chan_o != 2'b11));

   assert_mono_chan_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mono_view |-> (chan_o == cfg_chan_i));
endmodule

bind ccd_sample_seq sts_checker u_sts_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_i      (sync_i),
   .cfg_mono_i  (cfg_mono_i),
   .cfg_cds_i   (cfg_cds_i),
   .cfg_maxspd_i(cfg_maxspd_i),
   .cfg_rate_i  (cfg_rate_i),
   .cfg_chan_i  (cfg_chan_i),
   .vs_o        (vs_o),
   .rs_o        (rs_o),
   .cl_o        (cl_o),
   .chan_o      (chan_o),
   .slot_valid_o(slot_valid_o)
);

// File: tb/sim_ccd_sample_seq.sv
module sim_ccd_sample_seq;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       sync_i = 1'b0, clamp_req_i = 1'b0;
   logic       cfg_mono_i = 1'b0, cfg_cds_i = 1'b1, cfg_maxspd_i = 1'b0;
   logic [1:0] cfg_rate_i = 2'b00, cfg_chan_i = 2'b00, cfg_rs_adj_i = 2'b01;
   logic       vs_o, rs_o, cl_o, slot_valid_o;
   logic [1:0] chan_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   ccd_sample_seq u0 (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .clamp_req_i(clamp_req_i),
      .cfg_mono_i(cfg_mono_i), .cfg_cds_i(cfg_cds_i), .cfg_maxspd_i(cfg_maxspd_i),
      .cfg_rate_i(cfg_rate_i), .cfg_chan_i(cfg_chan_i), .cfg_rs_adj_i(cfg_rs_adj_i),
      .vs_o(vs_o), .rs_o(rs_o), .cl_o(cl_o), .chan_o(chan_o),
      .slot_valid_o(slot_valid_o)
   );

   task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   function automatic int ratio_of(bit mx, bit [1:0] rate);
      if (mx) return 2;
      if (rate == 2'b01) return 3;
      if (rate == 2'b10) return 8;
      return 6;
   endfunction

   // one pixel with the current configuration, starting idle on a falling edge
   task automatic run_pixel();
      int  r     = ratio_of(cfg_maxspd_i, cfg_rate_i);
      bit  emono = cfg_mono_i | cfg_maxspd_i | (cfg_rate_i == 2'b01);
      bit  cdsa  = cfg_cds_i & ~cfg_maxspd_i;
      int  pos   = 3 + int'(cfg_rs_adj_i);
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
      for (int n = 1; n <= r + 1; n++) begin
         bit evs, ers, ecl, eval;
         bit [1:0] ech;
         int slot;
         if (n <= r) begin
            evs  = (n == 1);
            ers  = cdsa ? (n == pos) : (n == 1);
            ecl  = clamp_req_i && (n == pos);
            slot = (r < 6) ? 0 : (n - 1) / 2;
            eval = emono ? (slot == 0) : (slot < 3);
            ech  = emono ? cfg_chan_i : ((slot < 3) ? 2'(slot) : 2'b11);
            chk("R2", "vs_o", {1'b0, vs_o}, {1'b0, evs});
            chk(cdsa ? "R3" : "R4", "rs_o", {1'b0, rs_o}, {1'b0, ers});
            chk("R5", "cl_o", {1'b0, cl_o}, {1'b0, ecl});
            chk(emono ? "R8" : "R7", "slot_valid_o", {1'b0, slot_valid_o}, {1'b0, eval});
            chk(emono ? "R8" : "R7", "chan_o", chan_o, ech);
         end else begin
            ech = emono ? cfg_chan_i : 2'b00;
            chk("R6", "idle strobes", {1'b0, vs_o | rs_o | cl_o}, 2'b00);
            chk("R6", "idle valid", {1'b0, slot_valid_o}, 2'b00);
            chk("R6", "idle chan_o", chan_o, ech);
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset held
      chk("R1", "strobes in reset", {vs_o | rs_o, cl_o | slot_valid_o}, 2'b00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "strobes after reset", {vs_o | rs_o, cl_o | slot_valid_o}, 2'b00);

      // sweep every configuration
      for (int mx = 0; mx < 2; mx++)
         for (int rt = 0; rt < 4; rt++)
            for (int mo = 0; mo < 2; mo++)
               for (int cd = 0; cd < 2; cd++)
                  for (int aj = 0; aj < 4; aj++)
                     for (int cr = 0; cr < 2; cr++) begin
                        cfg_maxspd_i = mx[0];
                        cfg_rate_i   = 2'(rt);
                        cfg_mono_i   = mo[0];
                        cfg_cds_i    = cd[0];
                        cfg_rs_adj_i = 2'(aj);
                        cfg_chan_i   = 2'((mx + rt + mo + aj) % 3);
                        clamp_req_i  = cr[0];
                        run_pixel();
                     end

      // R9: early sync restarts the pixel and drops the armed clamp
      cfg_maxspd_i = 1'b0; cfg_rate_i = 2'b00; cfg_mono_i = 1'b0;
      cfg_cds_i = 1'b1; cfg_rs_adj_i = 2'b01; clamp_req_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;                       // step 1, clamp request taken next edge
      @(negedge clk);                      // step 2
      chk("R9", "step2 chan_o", chan_o, 2'b00);
      sync_i = 1'b1; clamp_req_i = 1'b0;
      @(negedge clk);                      // restarted: step 1
      sync_i = 1'b0;
      chk("R9", "restart vs_o", {1'b0, vs_o}, 2'b01);
      chk("R9", "restart chan_o", chan_o, 2'b00);
      @(negedge clk);                      // step 2
      chk("R9", "restart step2 vs_o", {1'b0, vs_o}, 2'b00);
      @(negedge clk);                      // step 3
      chk("R9", "restart step3 chan_o", chan_o, 2'b01);
      @(negedge clk);                      // step 4: reset sample, clamp dropped
      chk("R9", "restart rs_o", {1'b0, rs_o}, 2'b01);
      chk("R9", "dropped clamp", {1'b0, cl_o}, 2'b00);
      repeat (4) @(negedge clk);
      chk("R6", "idle after restart", {vs_o | rs_o, cl_o | slot_valid_o}, 2'b00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule